// File: doc/BRIEF.md
# DMA Master Control and Halt Flag Register

This block is the global run-control register of a four-channel DMA engine. It holds one master enable bit and two sticky error flags. The first flag records a non-maskable interrupt and the second records an address error. From these bits, and from each channel's own enable and transfer-end inputs, it drives a per-channel permit signal that the channel engines obey.

The error flags are deliberately hard to clear. Software must first read a flag as 1 and then write 0 to it. A read that lands in the same cycle as a new event returns 0 for that bit, but it still arms the clear. If a fresh event arrives between the read and the write, the arm is dropped. When a flag rises, each channel that is moving data is allowed to finish its current transfer unit before its permit falls. Clearing the master enable removes every permit at once.

The register sits behind a single-cycle port with write enable, read enable, write data and registered read data. The bit positions are: bit 0 master enable, bit 1 interrupt flag, bit 2 address-error flag. All other bits read as 0.

Top module: `dma_master_ctl`

## Requirements
- R1: After reset, the master enable, both flags, the read data and all permit outputs are 0.
- R2: Every write loads bit 0 of the write data into the master enable, and a read returns it in bit 0 of the read data in the cycle after the read strobe.
- R3: An interrupt pulse sets the interrupt flag (bit 1) from the next cycle, whether or not any channel is active. Writing 1 to bit 1 or bit 2 never sets a flag.
- R4: A flag clears only on a write with that bit 0 while its arm is set. A read that returns the flag as 1 sets the arm. Any later write consumes the arm, so a write of 0 with no read since the previous write leaves the flag at 1.
- R5: A read in the same cycle as a flag-setting event returns 0 for that bit, yet arms the clear, so the next write of 0 clears the flag.
- R6: An event that sets a flag again after the arming read drops that flag's arm. A subsequent write of 0 leaves the flag at 1.
- R7: An address-error event sets bit 2 with the same clear rules as bit 1, using an independent arm, and it stops channels the same way.
- R8: With both flags 0, permit[i] equals master enable AND channel enable[i] AND NOT transfer-end[i], combinationally from the enable inputs.
- R9: While a flag is 1, a permitted channel keeps its permit until a unit-done pulse for that channel, and loses it from the following cycle. A channel not permitted when the flag is seen stays blocked even if it becomes enabled.
- R10: A write that clears the master enable drops every permit from the next cycle.
- R11: Once both flags are 0 again, permits follow R8 from the second cycle after the clearing write.
- R12: A flag-setting event in the same cycle as an armed write of 0 wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| nmiPulse | input | 1 | Non-maskable interrupt event, one cycle |
| addrErr | input | 1 | Address-error event, one cycle |
| chanEnable | input | 4 | Per-channel enable |
| chanEnd | input | 4 | Per-channel transfer-end status |
| unitDone | input | 4 | Per-channel transfer-unit boundary pulse |
| permit | output | 4 | Per-channel transfer permission |

## Verification
Two pairs of functions can fall in the same cycle. The first is a flag-setting event arriving together with a register read. The second is the same event arriving together with an armed write of 0. The bench drives the event pulse and the port strobe in one cycle. It judges the first case by checking that the read data shows 0 and that the following write of 0 still clears the flag. It judges the second case by checking that the flag is still 1 when read afterwards. A sweep over every enable, channel-enable and transfer-end combination checks the permit equation.

// File: rtl/dma_master_pkg.sv
package dma_master_pkg;
  localparam int EN_BIT  = 0;
  localparam int NMI_BIT = 1;
  localparam int AE_BIT  = 2;
  localparam int NFLAG   = 2;

  typedef struct packed {
    logic loadEn;
    logic enVal;
    logic setNmi;
    logic setAe;
    logic clrNmi;
    logic clrAe;
    logic capRd;
  } ctlStrobe_t;
endpackage

// File: rtl/dma_master_ctrl.sv
module dma_master_ctrl
  import dma_master_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              nmiPulse,
  input  logic              addrErr,
  input  logic              nmiFlag,
  input  logic              aeFlag,
  output ctlStrobe_t        strobe
);
  logic [NFLAG-1:0] evt, flagNow, wrBit, arm, armNext, clearNow;

  assign evt     = {addrErr, nmiPulse};
  assign flagNow = {aeFlag, nmiFlag};
  assign wrBit   = {wrData[AE_BIT], wrData[NMI_BIT]};

  for (genvar g = 0; g < NFLAG; g++) begin : g_arm
    always_comb begin
      clearNow[g] = wrEn & ~wrBit[g] & arm[g] & ~evt[g];
      if (evt[g])      armNext[g] = rdEn;
      else if (rdEn)   armNext[g] = flagNow[g] & ~clearNow[g];
      else if (wrEn)   armNext[g] = 1'b0;
      else             armNext[g] = arm[g];
    end

    always_ff @(posedge clk) begin
      if (!rstN) arm[g] <= 1'b0;
      else       arm[g] <= armNext[g];
    end
  end

  always_comb begin
    strobe.loadEn = wrEn;
    strobe.enVal  = wrData[EN_BIT];
    strobe.setNmi = evt[0];
    strobe.setAe  = evt[1];
    strobe.clrNmi = clearNow[0];
    strobe.clrAe  = clearNow[1];
    strobe.capRd  = rdEn;
  end
endmodule

// File: rtl/dma_master_dp.sv
module dma_master_dp
  import dma_master_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  output logic              masterEn,
  output logic              nmiFlag,
  output logic              aeFlag,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] rdView;

  always_comb begin
    rdView          = '0;
    rdView[EN_BIT]  = masterEn;
    rdView[NMI_BIT] = nmiFlag;
    rdView[AE_BIT]  = aeFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterEn <= 1'b0;
      nmiFlag  <= 1'b0;
      aeFlag   <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strobe.loadEn) masterEn <= strobe.enVal;
      if (strobe.setNmi)      nmiFlag <= 1'b1;
      else if (strobe.clrNmi) nmiFlag <= 1'b0;
      if (strobe.setAe)       aeFlag <= 1'b1;
      else if (strobe.clrAe)  aeFlag <= 1'b0;
      if (strobe.capRd) rdData <= rdView;
    end
  end
endmodule

// File: rtl/dma_master_gate.sv
module dma_master_gate #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           masterEn,
  input  logic           haltReq,
  input  logic [NCH-1:0] chanEnable,
  input  logic [NCH-1:0] chanEnd,
  input  logic [NCH-1:0] unitDone,
  output logic [NCH-1:0] permit
);
  logic [NCH-1:0] basePermit, stopped;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign basePermit[c] = masterEn & chanEnable[c] & ~chanEnd[c];
    assign permit[c]     = basePermit[c] & ~stopped[c];

    always_ff @(posedge clk) begin
      if (!rstN)
        stopped[c] <= 1'b0;
      else
        stopped[c] <= haltReq & (stopped[c] | unitDone[c] | ~basePermit[c]);
    end
  end
endmodule

// File: rtl/dma_master_ctl.sv
module dma_master_ctl
  import dma_master_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              nmiPulse,
  input  logic              addrErr,
  input  logic [NCH-1:0]    chanEnable,
  input  logic [NCH-1:0]    chanEnd,
  input  logic [NCH-1:0]    unitDone,
  output logic [NCH-1:0]    permit
);
  ctlStrobe_t strobe;
  logic masterEn, nmiFlag, aeFlag, haltReq;

  assign haltReq = nmiFlag | aeFlag;

  dma_master_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .nmiPulse(nmiPulse), .addrErr(addrErr), .nmiFlag(nmiFlag),
    .aeFlag(aeFlag), .strobe(strobe)
  );

  dma_master_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .masterEn(masterEn),
    .nmiFlag(nmiFlag), .aeFlag(aeFlag), .rdData(rdData)
  );

  dma_master_gate #(.NCH(NCH)) u_gate (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .haltReq(haltReq),
    .chanEnable(chanEnable), .chanEnd(chanEnd), .unitDone(unitDone),
    .permit(permit)
  );
endmodule

// File: rtl/dma_master_chk.sv
module dma_master_chk
  import dma_master_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              nmiPulse,
  input logic              addrErr,
  input logic [NCH-1:0]    chanEnable,
  input logic [NCH-1:0]    chanEnd,
  input logic [NCH-1:0]    unitDone,
  input logic [NCH-1:0]    permit,
  input logic              masterEn,
  input logic              nmiFlag,
  input logic              aeFlag
);
  // R3 and R12: an event always leaves the flag set, even against a clearing write
  a_r3_nmi_sets: assert property (@(posedge clk) disable iff (!rstN)
    nmiPulse |=> nmiFlag);
  a_r7_ae_sets: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |=> aeFlag);

  // R3: without an event a clear flag stays clear
  a_r3_no_self_set: assert property (@(posedge clk) disable iff (!rstN)
    (!nmiFlag && !nmiPulse) |=> !nmiFlag);

  // R4: a flag falls only after a write carrying 0 in its bit
  a_r4_clear_needs_write0: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nmiFlag) |-> ($past(wrEn) && !$past(wrData[NMI_BIT])));
  a_r7_ae_clear_needs_write0: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aeFlag) |-> ($past(wrEn) && !$past(wrData[AE_BIT])));

  // R8: no permit without master enable, channel enable and no transfer end
  a_r8_permit_conditions: assert property (@(posedge clk) disable iff (!rstN)
    (permit & ~(chanEnable & ~chanEnd)) == '0);

  // R10: master enable low means no permits
  a_r10_disable_blocks: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |-> (permit == '0));

  // R9: a unit boundary seen under a halt removes that channel's permit
  for (genvar c = 0; c < NCH; c++) begin : g_a
    a_r9_stop_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
      ((nmiFlag || aeFlag) && unitDone[c] && !nmiPulse) |=> !permit[c] || !nmiFlag && !aeFlag);
  end
endmodule

bind dma_master_ctl dma_master_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dma_master_ctl_bench.sv
module dma_master_ctl_bench;
  localparam int NCH = 4;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, nmiPulse = 1'b0, addrErr = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [NCH-1:0] chanEnable = '0, chanEnd = '0, unitDone = '0;
  logic [NCH-1:0] permit;
  int nVec = 0;
  int nBad = 0;
  logic [DW-1:0] got;

  always #2 clk = ~clk;

  dma_master_ctl #(.NCH(NCH), .DATA_W(DW)) u_dma_master_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .nmiPulse(nmiPulse), .addrErr(addrErr),
    .chanEnable(chanEnable), .chanEnd(chanEnd), .unitDone(unitDone),
    .permit(permit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doWrite(input logic [DW-1:0] d);
    wrEn = 1'b1; wrData = d; tick(); wrEn = 1'b0;
  endtask

  task automatic doRead(output logic [DW-1:0] d);
    rdEn = 1'b1; tick(); rdEn = 1'b0; d = rdData;
  endtask

  task automatic pulseNmi();
    nmiPulse = 1'b1; tick(); nmiPulse = 1'b0;
  endtask

  task automatic pulseAe();
    addrErr = 1'b1; tick(); addrErr = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nVec++; nBad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1 rdData", rdData, 0);
    check("R1 permit", permit, 0);
    doRead(got); check("R1 read", got, 0);

    // R2 master enable
    doWrite(8'h01); doRead(got); check("R2 en set", got, 8'h01);
    doWrite(8'h00); doRead(got); check("R2 en clear", got, 8'h00);

    // R3 writes of 1 do not set flags, event sets
    doWrite(8'h06); doRead(got); check("R3 write1 no set", got, 8'h00);
    pulseNmi(); doWrite(8'h00);
    // R4 unarmed write leaves flag
    doRead(got); check("R4 unarmed write", got, 8'h02);
    doWrite(8'h02); doWrite(8'h00);
    doRead(got); check("R4 arm consumed", got, 8'h02);
    doWrite(8'h00); doRead(got); check("R4 armed clear", got, 8'h00);

    // R5 read in the set cycle
    nmiPulse = 1'b1; rdEn = 1'b1; tick(); nmiPulse = 1'b0; rdEn = 1'b0;
    check("R5 read shows 0", rdData, 8'h00);
    doWrite(8'h00); doRead(got); check("R5 clear after same-cycle read", got, 8'h00);

    // R6 event between read and write
    pulseNmi(); doRead(got); pulseNmi(); doWrite(8'h00);
    doRead(got); check("R6 arm dropped", got, 8'h02);
    doWrite(8'h00); doRead(got); check("R6 later clear", got, 8'h00);

    // R12 event with armed write
    pulseNmi(); doRead(got);
    nmiPulse = 1'b1; wrEn = 1'b1; wrData = 8'h00; tick(); nmiPulse = 1'b0; wrEn = 1'b0;
    doRead(got); check("R12 event wins", got, 8'h02);
    doWrite(8'h00); doRead(got); check("R12 later clear", got, 8'h00);

    // R7 address-error flag with independent arm
    nmiPulse = 1'b1; addrErr = 1'b1; tick(); nmiPulse = 1'b0; addrErr = 1'b0;
    doRead(got); check("R7 both set", got, 8'h06);
    pulseAe(); doWrite(8'h00);
    doRead(got); check("R7 independent arm", got, 8'h04);
    doWrite(8'h00); doRead(got); check("R7 ae clear", got, 8'h00);
    addrErr = 1'b1; rdEn = 1'b1; tick(); addrErr = 1'b0; rdEn = 1'b0;
    check("R7 same-cycle read", rdData, 8'h00);
    doWrite(8'h00); doRead(got); check("R7 same-cycle clear", got, 8'h00);

    // R8 exhaustive permit sweep
    for (int e = 0; e < 2; e++) begin
      doWrite(DW'(e));
      for (int d = 0; d < 16; d++) begin
        for (int t = 0; t < 16; t++) begin
          chanEnable = NCH'(d); chanEnd = NCH'(t); #1;
          check("R8 permit", permit, (e == 1) ? ((d & ~t) & 4'hF) : 0);
        end
      end
    end
    chanEnd = '0;

    // R9 stop at unit boundary, R11 resume
    doWrite(8'h01); chanEnable = 4'b0111; #1;
    check("R9 before halt", permit, 4'b0111);
    pulseNmi(); check("R9 held until boundary", permit, 4'b0111);
    unitDone = 4'b0001; tick(); unitDone = '0;
    check("R9 ch0 stopped", permit, 4'b0110);
    chanEnable = 4'b1111; #1;
    check("R9 idle channel blocked", permit, 4'b0110);
    unitDone = 4'b0110; tick(); unitDone = '0;
    check("R9 all stopped", permit, 4'b0000);
    doRead(got); check("R9 flag visible", got, 8'h03);
    doWrite(8'h01); tick();
    check("R11 resume", permit, 4'b1111);

    // R10 disable drops all
    doWrite(8'h00); check("R10 disable", permit, 4'b0000);

    // R7 address error also halts channels
    doWrite(8'h01); pulseAe();
    check("R7 held until boundary", permit, 4'b1111);
    unitDone = 4'b1111; tick(); unitDone = '0;
    check("R7 ae halts", permit, 4'b0000);
    doRead(got); doWrite(8'h01); tick();
    check("R11 resume after ae", permit, 4'b1111);

    finishRun();
  end
endmodule